// File: doc/BRIEF.md
# Cube Unit with Selectable Iterative or Pipelined Architecture

The block raises an unsigned operand to the third power and returns the low bits of the product, which has the same width as the operand. A build-time parameter chooses how the work is arranged. The iterative arrangement owns a single multiplier, driven by a two-state controller and a step counter, and spends several cycles on each operand. The pipelined arrangement unrolls the multiplications into a chain of register stages and accepts a fresh operand on every cycle. Both arrangements have the same latency. Their throughputs differ by the exponent, which is three by default.

The caller raises `in_valid` for one cycle with the operand on `in_op`. Exactly three cycles later the result appears on `out_res`, qualified by a one-cycle `out_valid` pulse. There is no backpressure. In the iterative arrangement the controller has two states. `IDLE` takes the transition *accept* to `RUN` when an operand is presented. `RUN` takes the transition *step* back to itself while the step counter has not reached its last value, and the transition *finish* back to `IDLE` on the last step. That last step also raises the done pulse. Operands presented while the controller is in `RUN` are dropped.

Top module: `cube_unit`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `out_valid` is low. No result appears until an operand is presented after reset.
- R2: Whenever `out_valid` is high, `out_res` equals the cube of the accepted operand, reduced modulo 2^32 (the low 32 bits of the product).
- R3: In the iterative arrangement, an operand accepted in cycle n produces `out_valid` high in cycle n+3.
- R4: In the iterative arrangement, `in_valid` in the two cycles after an accepted operand is ignored. It produces no result and does not change the pending one.
- R5: In the iterative arrangement, an operand presented in the same cycle as a result is accepted, so operands presented every third cycle are all taken.
- R6: In the pipelined arrangement, every cycle with `in_valid` high is accepted, and its result appears exactly three cycles later, in input order, including back-to-back inputs.
- R7: `out_valid` is high for exactly one cycle per accepted operand.
- R8: A synchronous reset while operands are in flight discards them. None of them later raises `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Unsigned operand |
| out_valid | output | 1 | One-cycle result qualifier |
| out_res | output | 32 | Low 32 bits of the cube |

## Verification
The bench builds two copies at the default 32-bit width and exponent three, one with `ARCH` set to the iterative arrangement and one with it set to the pipelined arrangement. Both copies receive the same stimulus. The stimulus sweeps the operands 0 to 1023 twice, once with a strobe on every cycle and once on every third cycle, so the iterative copy meets both the dropped-start window and the start that coincides with a done pulse. Wrap-around operands up to all ones, a long pseudo-random stretch, and a reset in mid-flight bring truncation, arbitrary gaps and discard behaviour within reach. The expected values come from a 32-bit product of three factors, together with a small acceptance model for the iterative copy.

// File: rtl/cube_pkg.sv
package cube_pkg;

    // Architecture selector values for the ARCH parameter
    localparam int ARCH_ITER = 0;
    localparam int ARCH_PIPE = 1;

    // Controller states of the iterative arrangement
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } iter_state_e;

endpackage

// File: rtl/cube_iter.sv
module cube_iter
    import cube_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int POWER = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] op,
    output logic             done,
    output logic [WIDTH-1:0] res
);

    localparam int             STEPS = POWER - 1;
    localparam int             SW    = (STEPS > 1) ? $clog2(STEPS + 1) : 1;
    localparam logic [SW-1:0]  LAST  = SW'(STEPS - 1);

    iter_state_e     state_q, state_d;
    logic [SW-1:0]   step_q;
    logic [WIDTH-1:0] base_q;
    logic [WIDTH-1:0] acc_q;
    logic            done_q;
    logic            take;
    logic            finish;

    assign take   = (state_q == ST_IDLE) && start;
    assign finish = (state_q == ST_RUN) && (step_q == LAST);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept, step, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (step_q == LAST) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Step counter
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else if (take) begin
            step_q <= '0;
        end else if (state_q == ST_RUN) begin
            step_q <= step_q + SW'(1);
        end
    end

    // Shared multiplier and operand hold
    always_ff @(posedge clk) begin
        if (take) begin
            base_q <= op;
            acc_q  <= op;
        end else if (state_q == ST_RUN) begin
            acc_q  <= acc_q * base_q;
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
        end
    end

    assign done = done_q;
    assign res  = acc_q;

endmodule

// File: rtl/cube_pipe.sv
module cube_pipe #(
    parameter int WIDTH = 32,
    parameter int POWER = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op,
    output logic             out_valid,
    output logic [WIDTH-1:0] res
);

    localparam int NST = POWER;

    logic [NST-1:0]   vld_q;
    logic [WIDTH-1:0] prod_q [NST];
    logic [WIDTH-1:0] base_q [NST-1];

    // Per-stage valid bits, cleared by reset
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            vld_q <= {vld_q[NST-2:0], in_valid};
        end
    end

    // Operand and partial product carried stage by stage
    always_ff @(posedge clk) begin
        prod_q[0] <= op;
        base_q[0] <= op;
        for (int i = 1; i < NST; i++) begin
            prod_q[i] <= prod_q[i-1] * base_q[i-1];
        end
        for (int i = 1; i < NST - 1; i++) begin
            base_q[i] <= base_q[i-1];
        end
    end

    assign out_valid = vld_q[NST-1];
    assign res       = prod_q[NST-1];

endmodule

// File: rtl/cube_unit.sv
module cube_unit
    import cube_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int POWER = 3,
    parameter int ARCH  = ARCH_ITER
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_op,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_res
);

    generate
        if (ARCH == ARCH_PIPE) begin : g_pipe
            cube_pipe #(
                .WIDTH (WIDTH),
                .POWER (POWER)
            ) u_pipe (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (in_valid),
                .op        (in_op),
                .out_valid (out_valid),
                .res       (out_res)
            );
        end else begin : g_iter
            cube_iter #(
                .WIDTH (WIDTH),
                .POWER (POWER)
            ) u_iter (
                .clk   (clk),
                .rst   (rst),
                .start (in_valid),
                .op    (in_op),
                .done  (out_valid),
                .res   (out_res)
            );
        end
    endgenerate

endmodule

// File: rtl/cube_unit_chk.sv
module cube_unit_chk
    import cube_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int POWER = 3,
    parameter int ARCH  = ARCH_ITER
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_op,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_res
);

    localparam int GW = $clog2(POWER + 1);

    logic [POWER-1:0] hist_v;
    logic [WIDTH-1:0] hist_op [POWER];
    logic [GW-1:0]    gap_q;

    function automatic logic [WIDTH-1:0] raise(input logic [WIDTH-1:0] b);
        logic [WIDTH-1:0] r;
        r = b;
        for (int i = 1; i < POWER; i++) begin
            r = r * b;
        end
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_v <= '0;
        end else begin
            hist_v <= {hist_v[POWER-2:0], in_valid};
        end
    end

    always_ff @(posedge clk) begin
        hist_op[0] <= in_op;
        for (int i = 1; i < POWER; i++) begin
            hist_op[i] <= hist_op[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (out_valid) begin
            gap_q <= GW'(1);
        end else if (gap_q < GW'(POWER)) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    generate
        if (ARCH == ARCH_PIPE) begin : g_pipe_chk
            // R6
            pipe_valid_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid == hist_v[POWER-1]);
            // R2
            pipe_data_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> out_res == raise(hist_op[POWER-1]));
        end else begin : g_iter_chk
            // R3
            iter_valid_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> hist_v[POWER-1]);
            // R2
            iter_data_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> out_res == raise(hist_op[POWER-1]));
            // R4
            iter_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> gap_q >= GW'(POWER));
        end
    endgenerate

endmodule

bind cube_unit cube_unit_chk #(
    .WIDTH (WIDTH),
    .POWER (POWER),
    .ARCH  (ARCH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_res   (out_res)
);

// File: tb/tb_cube_unit.sv
`timescale 1ns/1ps
module tb_cube_unit;
    import cube_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_op = '0;
    logic        it_valid, pp_valid;
    logic [31:0] it_res, pp_res;

    always #2.5 clk = ~clk;

    cube_unit #(.WIDTH(32), .POWER(3), .ARCH(ARCH_ITER)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .out_valid(it_valid), .out_res(it_res));

    cube_unit #(.WIDTH(32), .POWER(3), .ARCH(ARCH_PIPE)) dut_pipe (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .out_valid(pp_valid), .out_res(pp_res));

    int          checks = 0;
    int          bad = 0;
    int          k = 0;
    int          busy = 0;
    bit          finished = 0;
    string       ctx = "";
    logic        ev_i [4];
    logic        ev_p [4];
    logic [31:0] ed_i [4];
    logic [31:0] ed_p [4];
    logic [31:0] lfsr = 32'h1234_5678;

    function automatic logic [31:0] cube32(input logic [31:0] x);
        logic [31:0] c;
        c = x * x * x;
        return c;
    endfunction

    task automatic check_out(input string who, input string tags,
                             input logic av, input logic xv,
                             input logic [31:0] ad, input logic [31:0] xd);
        checks++;
        if (av !== xv) begin
            bad++;
            $display("FAIL %s %s valid actual=%0b expected=%0b cycle=%0d",
                     who, tags, av, xv, k);
        end
        if (xv) begin
            checks++;
            if (ad !== xd) begin
                bad++;
                $display("FAIL %s R2 result actual=%08h expected=%08h cycle=%0d",
                         who, ad, xd, k);
            end
        end
    endtask

    task automatic step(input logic r, input logic v, input logic [31:0] op);
        int s;
        @(negedge clk);
        s = k % 4;
        check_out("iter", {ctx, " R3 R4 R5 R7"}, it_valid, ev_i[s], it_res, ed_i[s]);
        check_out("pipe", {ctx, " R6 R7"}, pp_valid, ev_p[s], pp_res, ed_p[s]);
        ev_i[s] = 1'b0;
        ev_p[s] = 1'b0;
        if (r) begin
            for (int j = 0; j < 4; j++) begin
                ev_i[j] = 1'b0;
                ev_p[j] = 1'b0;
            end
            busy = 0;
        end else begin
            ev_p[(k+3)%4] = v;
            ed_p[(k+3)%4] = cube32(op);
            if (v && busy == 0) begin
                ev_i[(k+3)%4] = 1'b1;
                ed_i[(k+3)%4] = cube32(op);
                busy = 2;
            end else if (busy > 0) begin
                busy--;
            end
        end
        rst      = r;
        in_valid = v;
        in_op    = op;
        k++;
    endtask

    task automatic next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
    endtask

    logic [31:0] corners [8];

    initial begin
        corners = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
                    32'h0000_0800, 32'h0000_FFFF, 32'h0020_0001, 32'h7FFF_FFFF};
        for (int j = 0; j < 4; j++) begin
            ev_i[j] = 1'b0;
            ev_p[j] = 1'b0;
            ed_i[j] = '0;
            ed_p[j] = '0;
        end

        // R1: reset state, with strobes that must be ignored during reset
        ctx = "R1";
        for (int j = 0; j < 4; j++) step(1'b1, j[0], 32'd5);
        for (int j = 0; j < 4; j++) step(1'b0, 1'b0, '0);

        // R6 back-to-back sweep; R4 iterative drops two of every three
        ctx = "R6";
        for (int j = 0; j < 1024; j++) step(1'b0, 1'b1, j);

        // R5: strobe every third cycle, all taken by both
        ctx = "R5";
        for (int j = 0; j < 3072; j++) step(1'b0, (j % 3) == 0, j / 3);

        // R2: wrap-around corners, back-to-back then spaced
        ctx = "R2";
        for (int j = 0; j < 8; j++) step(1'b0, 1'b1, corners[j]);
        for (int j = 0; j < 32; j++) step(1'b0, (j % 4) == 0, corners[j/4]);

        // R4 and R7 under pseudo-random gaps and operands
        ctx = "R4";
        for (int j = 0; j < 3000; j++) begin
            next_rand();
            step(1'b0, lfsr[3] ^ lfsr[11], lfsr);
        end

        // R8: reset while operands are in flight
        ctx = "R8";
        step(1'b0, 1'b1, 32'd7);
        step(1'b0, 1'b1, 32'd9);
        step(1'b1, 1'b1, 32'd11);
        for (int j = 0; j < 6; j++) step(1'b0, 1'b0, '0);
        step(1'b0, 1'b1, 32'd13);
        for (int j = 0; j < 6; j++) step(1'b0, 1'b0, '0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog R1 R6 actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule